// File: doc/BRIEF.md
# Asynchronous Single-Bit Static RAM Access Controller

This block sits between a clocked host and an external asynchronous static memory of 65536 one-bit words with separate input and output data pins. The host hands over one access at a time through a valid/ready handshake. Each request carries an address, a write flag and a data bit. The controller drives an active-low select and an active-low write strobe, holds the address and write data steady, and for reads captures the returned bit.

The memory's minimum times are module parameters in nanoseconds. These cover address setup, write pulse width, select-to-end-of-write, address-valid-to-end-of-write, data setup, read access and cycle time. They are turned into clock counts by rounding up against a clock-period parameter, and every count is at least one cycle. A write opens the select window first, then pulses the write strobe inside it. The strobe is released one clock before the select, so the rising write strobe always ends the write. A read keeps the select low with the strobe high for the access count, then samples the data-out pin. After every access the select stays high for a gap that makes the full cycle at least the cycle-time count. This gap also lets the memory's output turn around cleanly.

Top module: `sram1_ctrl`

## Requirements
- R1: While reset is low, `mem_cs_n` and `mem_we_n` are high, `req_ready` and `rsp_valid` are low, and a request presented during reset is not taken.
- R2: `req_ready` is high only when no access is in progress. A request is taken on a rising edge where `req_valid` and `req_ready` are both high, and `mem_cs_n` goes low on that same edge. A request held high while busy starts no access.
- R3: A write first keeps `mem_cs_n` low with `mem_we_n` high for NA = ceil(T_ASU_NS / CLK_PERIOD_NS) cycles (at least 1), and only then drives `mem_we_n` low.
- R4: `mem_we_n` stays low for NW cycles. NW is the largest of ceil(T_WP_NS/clk), ceil(T_AW_NS/clk) - NA, ceil(T_CSW_NS/clk) - NA and ceil(T_DS_NS/clk) - NA, and at least 1.
- R5: `mem_we_n` rises exactly one cycle before `mem_cs_n` rises, so the write lands in the memory on the rising edge of `mem_we_n`.
- R6: `mem_addr` and `mem_din` take the request's values on the accepting edge and do not change while `mem_cs_n` is low.
- R7: A read keeps `mem_cs_n` low and `mem_we_n` high for NR = ceil(T_ACC_NS/clk) cycles. It then samples `mem_dout` and presents it on `rsp_rdata` with `rsp_valid` high for exactly one cycle.
- R8: After each access `mem_cs_n` stays high for max(1, NC - L) cycles, where NC = ceil(T_CYC_NS/clk) and L is the number of cycles the select was low. One idle cycle with `req_ready` high follows, so falling select edges are at least NC cycles apart.
- R9: Every time count is a rounded-up quotient with a floor of 1. A time that is not a whole number of clock periods gets the next whole count.
- R10: `mem_we_n` is never low while `mem_cs_n` is high.
- R11: A write produces no `rsp_valid` pulse. `rsp_valid` only follows a read window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_addr | input | ADDR_W | Word address of the request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 1 | Bit to write |
| rsp_valid | output | 1 | One-cycle pulse: read bit available |
| rsp_rdata | output | 1 | Captured read bit |
| mem_addr | output | ADDR_W | Address lines to the memory |
| mem_din | output | 1 | Data-in line to the memory |
| mem_dout | input | 1 | Data-out line from the memory |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_we_n | output | 1 | Active-low write strobe |

## Verification
The assertions assume that the host keeps `req_valid` and the payload steady from one falling clock edge to the next. They also assume the memory model answers a read combinationally while select is low and the strobe is high, and stores the data-in bit on the strobe's rising edge. The bench drives every input at falling edges only. Its model follows exactly that behaviour, and it changes the held request's payload in the middle of an access to show that the latched lines ignore it. The timing parameters are set so that the results are not whole numbers of clock periods and the cycle time dominates, so the rounding and the gap stretch both show up in the cycle counts.

// File: rtl/sram1_pkg.sv
package sram1_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ASU  = 3'd1,
    ST_WLOW = 3'd2,
    ST_WEND = 3'd3,
    ST_READ = 3'd4,
    ST_GAP  = 3'd5
  } acc_state_e;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // rounded-up clock count, never below one cycle (R9)
  function automatic int ns_to_clk(input int t_ns, input int clk_ns);
    int c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return max2(c, 1);
  endfunction

  // write-strobe low length: pulse width, plus everything measured to the
  // end of write that the setup phase has not already covered
  function automatic int wlow_len(input int wp_ns, input int aw_ns,
                                  input int csw_ns, input int ds_ns,
                                  input int asu_cyc, input int clk_ns);
    int r;
    r = ns_to_clk(wp_ns, clk_ns);
    r = max2(r, ns_to_clk(aw_ns, clk_ns) - asu_cyc);
    r = max2(r, ns_to_clk(csw_ns, clk_ns) - asu_cyc);
    r = max2(r, ns_to_clk(ds_ns, clk_ns) - asu_cyc);
    return max2(r, 1);
  endfunction

  function automatic int gap_len(input int cyc_cnt, input int busy_cnt);
    return max2(1, cyc_cnt - busy_cnt);
  endfunction

endpackage

// File: rtl/sram1_timer.sv
module sram1_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/sram1_seq.sv
module sram1_seq
  import sram1_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int N_ASU = 1,
  parameter int N_WP  = 1,
  parameter int N_ACC = 1,
  parameter int G_WR  = 1,
  parameter int G_RD  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_we,
  input  logic             tmr_zero,
  output acc_state_e       st_q,
  output acc_state_e       st_d,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             acc_fire,
  output logic             rd_sample,
  output logic             req_ready
);

  localparam logic [CNT_W-1:0] V_ASU = CNT_W'(N_ASU - 1);
  localparam logic [CNT_W-1:0] V_WP  = CNT_W'(N_WP - 1);
  localparam logic [CNT_W-1:0] V_ACC = CNT_W'(N_ACC - 1);
  localparam logic [CNT_W-1:0] V_GWR = CNT_W'(G_WR - 1);
  localparam logic [CNT_W-1:0] V_GRD = CNT_W'(G_RD - 1);

  assign req_ready = rst_n && (st_q == ST_IDLE);
  assign acc_fire  = req_valid && req_ready;
  assign rd_sample = (st_q == ST_READ) && tmr_zero;

  always_comb begin
    st_d    = st_q;
    tmr_val = '0;
    unique case (st_q)
      ST_IDLE: begin
        if (acc_fire) begin
          st_d    = req_we ? ST_ASU : ST_READ;
          tmr_val = req_we ? V_ASU : V_ACC;
        end
      end
      ST_ASU: begin
        if (tmr_zero) begin
          st_d    = ST_WLOW;
          tmr_val = V_WP;
        end
      end
      ST_WLOW: begin
        if (tmr_zero) st_d = ST_WEND;
      end
      ST_WEND: begin
        st_d    = ST_GAP;
        tmr_val = V_GWR;
      end
      ST_READ: begin
        if (tmr_zero) begin
          st_d    = ST_GAP;
          tmr_val = V_GRD;
        end
      end
      ST_GAP: begin
        if (tmr_zero) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign tmr_load = (st_d != st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

endmodule

// File: rtl/sram1_pins.sv
module sram1_pins
  import sram1_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  acc_state_e        st_d,
  input  logic              acc_fire,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_wdata,
  input  logic              rd_sample,
  input  logic              mem_dout,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_din,
  output logic              mem_cs_n,
  output logic              mem_we_n,
  output logic              rsp_valid,
  output logic              rsp_rdata
);

  logic sel_on;
  logic wr_on;

  assign sel_on = (st_d == ST_ASU) || (st_d == ST_WLOW) ||
                  (st_d == ST_WEND) || (st_d == ST_READ);
  assign wr_on  = (st_d == ST_WLOW);

  // strobes registered from the next state: glitch-free pin levels
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_cs_n <= 1'b1;
      mem_we_n <= 1'b1;
    end else begin
      mem_cs_n <= !sel_on;
      mem_we_n <= !wr_on;
    end
  end

  // address/data latched only on acceptance, frozen for the whole access
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      mem_din  <= 1'b0;
    end else if (acc_fire) begin
      mem_addr <= req_addr;
      mem_din  <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= 1'b0;
    end else begin
      rsp_valid <= rd_sample;
      if (rd_sample) rsp_rdata <= mem_dout;
    end
  end

endmodule

// File: rtl/sram1_ctrl.sv
module sram1_ctrl
  import sram1_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int CLK_PERIOD_NS = 20,
  parameter int T_ASU_NS      = 0,
  parameter int T_WP_NS       = 12,
  parameter int T_AW_NS       = 12,
  parameter int T_CSW_NS      = 12,
  parameter int T_DS_NS       = 10,
  parameter int T_ACC_NS      = 15,
  parameter int T_CYC_NS      = 15,
  parameter int CNT_W         = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic              req_wdata,
  output logic              rsp_valid,
  output logic              rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_din,
  input  logic              mem_dout,
  output logic              mem_cs_n,
  output logic              mem_we_n
);

  localparam int N_ASU = ns_to_clk(T_ASU_NS, CLK_PERIOD_NS);
  localparam int N_WP  = wlow_len(T_WP_NS, T_AW_NS, T_CSW_NS, T_DS_NS,
                                  N_ASU, CLK_PERIOD_NS);
  localparam int N_ACC = ns_to_clk(T_ACC_NS, CLK_PERIOD_NS);
  localparam int N_CYC = ns_to_clk(T_CYC_NS, CLK_PERIOD_NS);
  localparam int L_WR  = N_ASU + N_WP + 1;
  localparam int G_WR  = gap_len(N_CYC, L_WR);
  localparam int G_RD  = gap_len(N_CYC, N_ACC);

  // named internal events, visible to the bound checker
  acc_state_e       st_q;
  acc_state_e       st_d;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero;
  logic             acc_fire;
  logic             rd_sample;

  sram1_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  sram1_seq #(
    .CNT_W (CNT_W),
    .N_ASU (N_ASU),
    .N_WP  (N_WP),
    .N_ACC (N_ACC),
    .G_WR  (G_WR),
    .G_RD  (G_RD)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_we    (req_we),
    .tmr_zero  (tmr_zero),
    .st_q      (st_q),
    .st_d      (st_d),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .acc_fire  (acc_fire),
    .rd_sample (rd_sample),
    .req_ready (req_ready)
  );

  sram1_pins #(.ADDR_W(ADDR_W)) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .st_d      (st_d),
    .acc_fire  (acc_fire),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rd_sample (rd_sample),
    .mem_dout  (mem_dout),
    .mem_addr  (mem_addr),
    .mem_din   (mem_din),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: rtl/sram1_ctrl_chk.sv
module sram1_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int N_WP   = 1,
  parameter int N_CYC  = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_din,
  input logic              mem_cs_n,
  input logic              mem_we_n,
  input logic              acc_fire,
  input logic              rd_sample
);

  logic [31:0] wl_cnt;
  logic [31:0] sf_cnt;
  logic        cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wl_cnt <= '0;
      sf_cnt <= 32'hFFFF_FFFF;
      cs_d   <= 1'b1;
    end else begin
      cs_d   <= mem_cs_n;
      wl_cnt <= mem_we_n ? 32'd0 : wl_cnt + 32'd1;
      if (cs_d && !mem_cs_n)            sf_cnt <= 32'd1;
      else if (sf_cnt != 32'hFFFF_FFFF) sf_cnt <= sf_cnt + 32'd1;
    end
  end

  p_reset_high_r1: assert property (@(posedge clk)
    !rst_n |=> (mem_cs_n && mem_we_n && !rsp_valid));

  p_ready_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_cs_n);

  p_fire_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> !mem_cs_n);

  p_addr_setup_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> $past(!mem_cs_n));

  p_we_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (wl_cnt == 32'(N_WP)));

  p_we_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_cs_n ##1 mem_cs_n));

  p_lines_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!mem_cs_n)) |-> ($stable(mem_addr) && $stable(mem_din)));

  p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_rsp_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sample |=> rsp_valid);

  p_gap_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cs_n) |=> mem_cs_n);

  p_cycle_min_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cs_n) |-> (sf_cnt >= 32'(N_CYC)));

  p_we_in_cs_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_cs_n);

  p_rsp_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!mem_cs_n && mem_we_n));

endmodule

bind sram1_ctrl sram1_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .N_WP   (N_WP),
  .N_CYC  (N_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_din   (mem_din),
  .mem_cs_n  (mem_cs_n),
  .mem_we_n  (mem_we_n),
  .acc_fire  (acc_fire),
  .rd_sample (rd_sample)
);

// File: tb/sram1_ctrl_bench.sv
module sram1_ctrl_bench;

  localparam int AW   = 16;
  localparam int CLK  = 20;
  localparam int TASU = 0;
  localparam int TWP  = 50;
  localparam int TAW  = 85;
  localparam int TCSW = 41;
  localparam int TDS  = 30;
  localparam int TACC = 70;
  localparam int TCYC = 190;

  function automatic int up(input int t);
    int q;
    q = t / CLK;
    if (q * CLK < t) q = q + 1;
    if (q < 1) q = 1;
    return q;
  endfunction

  function automatic int big(input int a, input int b);
    if (a > b) return a;
    return b;
  endfunction

  // expected counts restated from the requirements
  int e_asu, e_wp, e_acc, e_cyc, e_gw, e_gr;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          req_we = 1'b0;
  logic          req_wdata = 1'b0;
  logic          rsp_valid;
  logic          rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_din;
  logic          mem_dout;
  logic          mem_cs_n;
  logic          mem_we_n;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  logic mem_model [0:65535];

  always #10 clk = ~clk;

  sram1_ctrl #(
    .ADDR_W (AW), .CLK_PERIOD_NS (CLK), .T_ASU_NS (TASU), .T_WP_NS (TWP),
    .T_AW_NS (TAW), .T_CSW_NS (TCSW), .T_DS_NS (TDS), .T_ACC_NS (TACC),
    .T_CYC_NS (TCYC), .CNT_W (8)
  ) u_sram1_ctrl (
    .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
    .req_addr (req_addr), .req_we (req_we), .req_wdata (req_wdata),
    .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata), .mem_addr (mem_addr),
    .mem_din (mem_din), .mem_dout (mem_dout), .mem_cs_n (mem_cs_n),
    .mem_we_n (mem_we_n)
  );

  // memory model: stores on strobe rise inside select, answers reads at once
  always @(posedge mem_we_n) begin
    if (mem_cs_n === 1'b0) mem_model[mem_addr] = mem_din;
  end
  assign mem_dout = (!mem_cs_n && mem_we_n) ? mem_model[mem_addr] : 1'b0;

  task automatic check(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      finish_run();
    end
  end

  task automatic t_reset();
    int bad;
    bad = 0;
    req_valid = 1'b1;
    req_we    = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (!mem_cs_n || !mem_we_n || req_ready || rsp_valid) bad++;
    end
    check(bad, 0, "R1 outputs during reset");
    rst_n     = 1'b1;
    req_valid = 1'b0;
    @(negedge clk);
    check(int'(mem_cs_n), 1, "R1 request in reset not taken");
    check(int'(req_ready), 1, "R2 ready after reset");
  endtask

  task automatic t_write(input logic [AW-1:0] a, input logic d);
    int asu, wl, tail, gap, rsp, n;
    asu = 0; wl = 0; tail = 0; gap = 0; rsp = 0; n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = ~a;
    req_wdata = ~d;
    while (!req_ready && n < 200) begin
      if (!mem_cs_n && mem_we_n && wl == 0) asu++;
      else if (!mem_we_n) wl++;
      else if (!mem_cs_n) tail++;
      else gap++;
      if (rsp_valid) rsp++;
      n++;
      @(negedge clk);
    end
    check(asu, e_asu, "R3 setup cycles before strobe");
    check(wl, e_wp, "R4 R9 strobe low cycles");
    check(tail, 1, "R5 select held after strobe rise");
    check(int'(mem_model[a]), int'(d), "R5 R6 bit stored");
    check(gap, e_gw, "R8 write gap");
    check(rsp, 0, "R11 no response on write");
  endtask

  task automatic t_read(input logic [AW-1:0] a, input logic exp);
    int low, rsp, got, at, n;
    low = 0; rsp = 0; got = 0; at = 0; n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = a; req_wdata = ~exp;
    @(negedge clk);
    req_valid = 1'b0;
    req_addr  = ~a;
    while (!req_ready && n < 200) begin
      n++;
      if (!mem_cs_n && mem_we_n) low++;
      if (rsp_valid) begin
        rsp++;
        got = int'(rsp_rdata);
        at  = n;
      end
      @(negedge clk);
    end
    check(low, e_acc, "R7 R9 read window cycles");
    check(rsp, 1, "R7 single response pulse");
    check(at, e_acc + 1, "R7 response position");
    check(got, int'(exp), "R7 read data");
    check(n - e_acc, e_gr, "R8 read gap");
  endtask

  // request held high across a busy access: payload swapped mid-access
  task automatic t_held();
    int f1, f2, n;
    logic prev;
    f1 = 0; f2 = 0; n = 0;
    @(negedge clk);
    prev = mem_cs_n;
    req_valid = 1'b1; req_we = 1'b1; req_addr = 16'h0A5A; req_wdata = 1'b1;
    while (f2 == 0 && n < 200) begin
      @(negedge clk);
      n++;
      if (prev && !mem_cs_n) begin
        if (f1 == 0) begin
          f1 = n;
          req_addr  = 16'h0A5B;
          req_wdata = 1'b0;
        end else begin
          f2 = n;
          req_valid = 1'b0;
        end
      end
      prev = mem_cs_n;
    end
    check(f2 - f1, e_asu + e_wp + 1 + e_gw + 1, "R2 R8 select fall spacing");
    while (!req_ready && n < 400) begin
      @(negedge clk);
      n++;
    end
    check(int'(mem_model[16'h0A5A]), 1, "R2 R6 first held write");
    check(int'(mem_model[16'h0A5B]), 0, "R2 second held write");
  endtask

  initial begin
    e_asu = up(TASU);
    e_wp  = big(1, big(up(TWP), big(up(TAW) - e_asu,
                big(up(TCSW) - e_asu, up(TDS) - e_asu))));
    e_acc = up(TACC);
    e_cyc = up(TCYC);
    e_gw  = big(1, e_cyc - (e_asu + e_wp + 1));
    e_gr  = big(1, e_cyc - e_acc);
    for (int i = 0; i < 65536; i++) mem_model[i] = 1'b0;
    mem_model[16'h0A5B] = 1'b1;

    t_reset();
    t_write(16'h0000, 1'b1);
    t_write(16'hFFFF, 1'b1);
    t_write(16'h1234, 1'b0);
    t_read(16'h0000, 1'b1);
    t_read(16'hFFFF, 1'b1);
    t_read(16'h1234, 1'b0);
    t_read(16'h0005, 1'b0);
    t_write(16'h1234, 1'b1);
    t_read(16'h1234, 1'b1);
    t_held();
    t_read(16'h0A5A, 1'b1);
    t_read(16'h0A5B, 1'b0);
    finish_run();
  end

endmodule